// File: doc/BRIEF.md
# SPI Master Word Shift Engine

This block serializes one parallel word at a time onto an SPI link as the bus master, and returns the word received on the same clocks. Each word is configured when it is started. The configuration sets the clock polarity and phase, a word length from 4 to 32 bits, and the bit order. It also sets an optional three-wire mode, in which one bidirectional data pin carries either a transmit-only word or a receive-only word.

The serial clock comes from the system clock through a programmable half-period divider. SCK moves only while bits are being shifted. A sequencer outside this block drives chip select and builds multi-word messages. It uses a start pulse and a single-cycle done pulse, and it may assert chip select whenever the engine is idle, because SCK is then already at its idle level.

Top module: `spi_shift_master`

## Requirements
- R1: After reset the engine is idle, `busy` and `done` are low, `rx_data` is zero and `mosi_oe` is high.
- R2: Each SCK half-period lasts `div`+1 system cycles. A word of L bits produces exactly 2·L SCK transitions. `done` rises 2·L·(`div`+1) cycles after the clock edge that accepts `start`.
- R3: While idle, `sck` equals the `cpol` input, so it idles low for CPOL=0 and high for CPOL=1. The first transition of a word therefore leaves the idle level.
- R4: With CPHA=0 the first data bit is on `mosi` before the first SCK edge, and both sides sample on leading edges. With CPHA=1, data changes on leading edges and is sampled on trailing edges.
- R5: In four-wire mode, each SCK period shifts one bit out on `mosi` and samples one bit from `miso`. The received word appears on `rx_data` together with `done`.
- R6: `word_len` below 4 is treated as 4, and values above 32 are treated as 32. Received bits are right-aligned in `rx_data`, with all bits above the word length zero. Transmit bits at or above the word length are never sent.
- R7: With `lsb_first`=0, bit L-1 of the word is sent first and the first bit received becomes bit L-1 of `rx_data`. With `lsb_first`=1, bit 0 is sent and received first.
- R8: In three-wire mode (`three_wire`=1), the received data comes from `sdio_in` and `miso` is ignored. When `rx_only`=1, `mosi_oe` is low for the whole word and `rx_data` holds the word sampled from `sdio_in`. When `rx_only`=0, `mosi_oe` stays high and `rx_data` returns zero.
- R9: A `start` is accepted only while idle. The mode, length, order and divider are captured at acceptance, so input changes and `start` pulses during a word change neither its bits nor its timing.
- R10: `done` is a single-cycle pulse. It comes in the cycle after the final SCK edge, with `busy` already low and SCK back at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one word; ignored while busy |
| cpol | input | 1 | Clock polarity; also the idle SCK level |
| cpha | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing |
| lsb_first | input | 1 | 1 selects least significant bit first |
| three_wire | input | 1 | 1 selects the shared-data-pin mode |
| rx_only | input | 1 | In three-wire mode, 1 makes the word receive-only |
| word_len | input | 6 | Bits per word, clamped to 4..32 |
| div | input | 8 | SCK half-period minus one, in system cycles |
| tx_data | input | 32 | Word to transmit, right-aligned |
| miso | input | 1 | Serial input in four-wire mode |
| sdio_in | input | 1 | Level seen on the shared data pin in three-wire mode |
| busy | output | 1 | A word is in progress |
| done | output | 1 | One-cycle pulse at end of word |
| rx_data | output | 32 | Received word, right-aligned, valid from `done` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial output / shared pin output value |
| mosi_oe | output | 1 | Output enable for the data pin |

## Verification
The hardest case to reach is a `start` pulse, together with changed configuration and data inputs, arriving in the middle of a word. Without it the latching of R9 is never challenged. The stimulus raises `start` a few cycles into a slow word and flips `cpol` and `tx_data` at the same time. It then checks that the shifted bits, the cycle count and the single `done` pulse all match the word that was originally started. The bench slave model reproduces each of the four clock modes from counted SCK transitions. In three-wire receive it drives opposite data on `miso` and `sdio_in`, so a wrong input selection shows as inverted data.

// File: rtl/spi_eng_pkg.sv
// Package: shared types of the SPI master shift engine.
// Assumes: none; included first in compile order.
package spi_eng_pkg;

    // Per-word mode settings captured at start.
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
        logic three_wire;
        logic rx_only;
    } spi_mode_t;

    // Engine state.
    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_state_t;

endpackage

// File: rtl/spi_eng_tick.sv
// Module: spi_eng_tick
// Produces one tick every DIV+1 cycles while run is high. Each tick
// marks the end of an SCK half-period.
// Assumes: div is held stable while run is high.
module spi_eng_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    // Half-period counter, cleared whenever the engine is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: with a divider above zero, two ticks are never adjacent
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);

endmodule

// File: rtl/spi_eng_shreg.sv
// Module: spi_eng_shreg
// Transmit and receive shift registers with a selectable bit order.
// rx_word is the received word, right-aligned, and already includes
// any bit sampled in the current cycle.
// Assumes: ld_len and len are already clamped to MIN..MAX_W.
module spi_eng_shreg #(
    parameter int MAX_W = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MAX_W-1:0] tx_word,
    input  logic [LEN_W-1:0] ld_len,
    input  logic             ld_lsb,
    input  logic [LEN_W-1:0] len,
    input  logic             lsb,
    input  logic             shift_out,
    input  logic             sample,
    input  logic             sin,
    output logic             sout,
    output logic [MAX_W-1:0] rx_word
);

    logic [MAX_W-1:0] tx_q;
    logic [MAX_W-1:0] rx_q;
    logic [MAX_W-1:0] rx_cap;

    assign sout = lsb ? tx_q[0] : tx_q[MAX_W-1];

    // Insert the sampled bit at the end its order requires.
    always_comb begin
        rx_cap = rx_q;
        if (sample) begin
            rx_cap = lsb ? {sin, rx_q[MAX_W-1:1]} : {rx_q[MAX_W-2:0], sin};
        end
    end

    // Right-align: LSB-first bits accumulate from the top.
    assign rx_word = lsb ? (rx_cap >> (MAX_W - int'(len))) : rx_cap;

    // Transmit register: left-align MSB-first words on load, then shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= ld_lsb ? tx_word : (tx_word << (MAX_W - int'(ld_len)));
        end else if (shift_out) begin
            tx_q <= lsb ? (tx_q >> 1) : (tx_q << 1);
        end
    end

    // Receive register: cleared on load so unused upper bits read zero.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_cap;
        end
    end

    // R9: neither register is reloaded while a shift is requested
    p_no_load_mid_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !(shift_out || sample));

endmodule

// File: rtl/spi_shift_master.sv
// Module: spi_shift_master
// Single-word SPI master. Supports the four clock modes, a word length
// of MIN_W..MAX_W, either bit order and three-wire half-duplex words.
// The SCK half-period is div+1 system cycles.
// Assumes: chip select is handled outside; start is honoured only when idle.
module spi_shift_master
    import spi_eng_pkg::*;
#(
    parameter int MAX_W = 32,
    parameter int MIN_W = 4,
    parameter int DIV_W = 8,
    parameter int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             lsb_first,
    input  logic             three_wire,
    input  logic             rx_only,
    input  logic [LEN_W-1:0] word_len,
    input  logic [DIV_W-1:0] div,
    input  logic [MAX_W-1:0] tx_data,
    input  logic             miso,
    input  logic             sdio_in,
    output logic             busy,
    output logic             done,
    output logic [MAX_W-1:0] rx_data,
    output logic             sck,
    output logic             mosi,
    output logic             mosi_oe
);

    localparam int EC_W = LEN_W + 1;

    eng_state_t       state_q;
    spi_mode_t        mode_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_c;
    logic [DIV_W-1:0] div_q;
    logic [EC_W-1:0]  edge_q;
    logic [EC_W-1:0]  last_edge;
    logic             ph_q;
    logic             done_q;
    logic [MAX_W-1:0] rx_q;
    logic             tick;
    logic             accept;
    logic             leading;
    logic             is_last;
    logic             sample_en;
    logic             shift_en;
    logic             sin;
    logic [MAX_W-1:0] rx_word;

    // Clamp the requested word length into the supported range.
    always_comb begin
        if (word_len < LEN_W'(MIN_W))      len_c = LEN_W'(MIN_W);
        else if (word_len > LEN_W'(MAX_W)) len_c = LEN_W'(MAX_W);
        else                               len_c = word_len;
    end

    assign accept    = start && (state_q == ENG_IDLE);
    assign busy      = (state_q == ENG_SHIFT);
    assign leading   = !edge_q[0];
    assign last_edge = {len_q, 1'b0} - EC_W'(1);
    assign is_last   = (edge_q == last_edge);
    assign sample_en = tick && (mode_q.cpha ? !leading : leading);
    assign shift_en  = tick && (mode_q.cpha ? (leading && edge_q != '0)
                                            : (!leading && !is_last));
    assign sin       = mode_q.three_wire ? sdio_in : miso;

    assign sck     = busy ? (mode_q.cpol ^ ph_q) : cpol;
    assign mosi_oe = !(mode_q.three_wire && mode_q.rx_only);
    assign done    = done_q;
    assign rx_data = rx_q;

    spi_eng_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div_q),
        .tick  (tick)
    );

    spi_eng_shreg #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .tx_word   (tx_data),
        .ld_len    (len_c),
        .ld_lsb    (lsb_first),
        .len       (len_q),
        .lsb       (mode_q.lsb_first),
        .shift_out (shift_en),
        .sample    (sample_en),
        .sin       (sin),
        .sout      (mosi),
        .rx_word   (rx_word)
    );

    // Word sequencing: capture settings, count SCK edges, publish result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            mode_q  <= '0;
            len_q   <= LEN_W'(MIN_W);
            div_q   <= '0;
            edge_q  <= '0;
            ph_q    <= 1'b0;
            done_q  <= 1'b0;
            rx_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        state_q <= ENG_SHIFT;
                        mode_q  <= '{cpol: cpol, cpha: cpha, lsb_first: lsb_first,
                                     three_wire: three_wire, rx_only: rx_only};
                        len_q   <= len_c;
                        div_q   <= div;
                        edge_q  <= '0;
                        ph_q    <= 1'b0;
                    end
                end
                default: begin
                    if (tick) begin
                        ph_q   <= !ph_q;
                        edge_q <= edge_q + 1'b1;
                        if (is_last) begin
                            state_q <= ENG_IDLE;
                            done_q  <= 1'b1;
                            rx_q    <= (mode_q.three_wire && !mode_q.rx_only)
                                       ? '0 : rx_word;
                        end
                    end
                end
            endcase
        end
    end

    // R10: done lasts exactly one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done only follows a word in progress, with the engine now idle
    p_done_after_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R9: captured settings hold for the whole word
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mode_q) && $stable(len_q) && $stable(div_q)));

    // R2: SCK moves only on a half-period tick
    p_sck_only_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(sck));

    // R6: no received bit lands above the word length
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rx_data >> len_q) == '0));

    // R8: a three-wire transmit-only word returns zero
    p_txonly_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q.three_wire && !mode_q.rx_only) |-> (rx_data == '0));

endmodule

// File: tb/spi_shift_master_tb.sv
module spi_shift_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
    logic        three_wire = 1'b0, rx_only = 1'b0;
    logic [5:0]  word_len = 6'd8;
    logic [7:0]  div = 8'd0;
    logic [31:0] tx_data = '0;
    logic        miso, sdio_in;
    logic        busy, done, sck, mosi, mosi_oe;
    logic [31:0] rx_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spi_shift_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .cpha(cpha),
        .lsb_first(lsb_first), .three_wire(three_wire), .rx_only(rx_only),
        .word_len(word_len), .div(div), .tx_data(tx_data), .miso(miso),
        .sdio_in(sdio_in), .busy(busy), .done(done), .rx_data(rx_data),
        .sck(sck), .mosi(mosi), .mosi_oe(mosi_oe)
    );

    // Slave model state
    logic        trk = 1'b0;
    int          edges = 0;
    logic [31:0] pat = '0;
    int          s_len = 8;
    bit          s_cpha = 1'b0, s_lsb = 1'b0, s_swap = 1'b0;
    logic [31:0] cap = '0;
    logic        bitv = 1'b0;
    logic        mosi_prev = 1'b0;

    assign miso    = s_swap ? ~bitv : bitv;
    assign sdio_in = s_swap ? bitv : ~bitv;

    function automatic logic pbit(int k);
        return s_lsb ? pat[k] : pat[s_len - 1 - k];
    endfunction

    always @(negedge clk) mosi_prev <= mosi;

    always @(sck) begin
        if (trk) begin
            int idx;
            edges = edges + 1;
            if (((edges % 2) == 1) != s_cpha && ((edges - 1) / 2) < 32)
                cap[(edges - 1) / 2] = mosi_prev;
            idx = s_cpha ? (edges - 1) / 2 : edges / 2;
            if (idx < s_len) bitv = pbit(idx);
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int clamp_len(int l);
        if (l < 4) return 4;
        if (l > 32) return 32;
        return l;
    endfunction

    task automatic run_word(input bit pol, input bit pha, input bit lsb,
                            input bit tw, input bit rxo, input int len_in,
                            input int dv, input logic [31:0] tx,
                            input logic [31:0] p, input bit poke);
        int          l;
        int          cyc;
        logic [31:0] msk;
        logic [31:0] exp_rx;
        logic [31:0] exp_cap;
        l   = clamp_len(len_in);
        msk = (l == 32) ? 32'hFFFF_FFFF : ((32'd1 << l) - 1);
        @(negedge clk);
        cpol = pol; cpha = pha; lsb_first = lsb; three_wire = tw; rx_only = rxo;
        word_len = 6'(len_in); div = 8'(dv); tx_data = tx;
        s_len = l; s_cpha = pha; s_lsb = lsb; s_swap = tw && rxo;
        pat = p; edges = 0; cap = '0; bitv = pbit(0);
        @(negedge clk);
        check(sck == pol, "R3 idle level before start", {31'd0, sck}, {31'd0, pol});
        trk = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cyc = 0;
        check(busy && mosi_oe == !(tw && rxo), "R8 busy/oe in word",
              {30'd0, busy, mosi_oe}, {30'd0, 1'b1, !(tw && rxo)});
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 3) begin
                start = 1'b1; tx_data = ~tx; cpol = ~pol; word_len = 6'd7; div = 8'd0;
            end
            if (poke && cyc == 4) begin
                start = 1'b0; cpol = pol;
            end
            if (busy && mosi_oe != !(tw && rxo))
                check(1'b0, "R8 oe held for word", {31'd0, mosi_oe}, {31'd0, !(tw && rxo)});
        end
        trk = 1'b0;
        check(cyc == 2 * l * (dv + 1), "R2 start-to-done cycles", cyc, 2 * l * (dv + 1));
        check(edges == 2 * l, "R2 SCK transition count", edges, 2 * l);
        exp_rx = (tw && !rxo) ? 32'd0 : (p & msk);
        check(rx_data == exp_rx, "R5/R6/R7/R8 received word", rx_data, exp_rx);
        if (!(tw && rxo)) begin
            exp_cap = '0;
            for (int k = 0; k < l; k++) exp_cap[k] = lsb ? tx[k] : tx[l - 1 - k];
            check((cap & msk) == exp_cap, "R4/R7 bits seen by slave", cap & msk, exp_cap);
        end
        check(!busy && sck == pol, "R10 idle with SCK at rest at done",
              {30'd0, busy, sck}, {30'd0, 1'b0, pol});
        @(negedge clk);
        check(!done, "R10 done single cycle", {31'd0, done}, 32'd0);
        if (poke) check(!busy, "R9 start while busy ignored", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lens[6] = '{4, 5, 8, 12, 20, 32};
        repeat (3) @(negedge clk);
        check(!busy && !done && rx_data == 0 && mosi_oe, "R1 reset state",
              {busy, done, mosi_oe, rx_data[28:0]}, {3'b001, 29'd0});
        check(sck == 1'b0, "R3 idle low for CPOL=0", {31'd0, sck}, 32'd0);
        cpol = 1'b1;
        @(negedge clk);
        check(sck == 1'b1, "R3 idle high for CPOL=1", {31'd0, sck}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 R5 R6 R7: all modes, lengths and orders
        for (int m = 0; m < 4; m++) begin
            for (int li = 0; li < 6; li++) begin
                for (int o = 0; o < 2; o++) begin
                    logic [31:0] tx;
                    logic [31:0] p;
                    tx = 32'hA5C3_96F1 ^ (32'h0101_0101 * (m * 12 + li * 2 + o));
                    p  = 32'h3C6E_D21B + 32'h1357_9BDF * (m + li + o);
                    run_word(m[1], m[0], o[0], 1'b0, 1'b0, lens[li],
                             (li + o) % 3, tx, p, 1'b0);
                end
            end
        end
        // R6: length clamping
        run_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2,  1, 32'hFFFF_FFF6, 32'hFFFF_FFF9, 1'b0);
        run_word(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0,  0, 32'h0000_000B, 32'h0000_0006, 1'b0);
        run_word(0, 1, 0, 1'b0, 1'b0, 45, 0, 32'hDEAD_BEEF, 32'h8000_0001, 1'b0);
        // R8: three-wire transmit-only and receive-only
        run_word(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8,  1, 32'h0000_00C5, 32'h0000_005A, 1'b0);
        run_word(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 12, 0, 32'h0000_0A3C, 32'h0000_0FFF, 1'b0);
        run_word(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16, 0, 32'h0000_FFFF, 32'h0000_B4D2, 1'b0);
        run_word(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 20, 2, 32'h0000_0000, 32'h000E_1D07, 1'b0);
        // R9: start and input changes during a word
        run_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8, 3, 32'h0000_0096, 32'h0000_0069, 1'b1);
        run_word(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6, 2, 32'h0000_0021, 32'h0000_0033, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule